// File: doc/BRIEF.md
# Instruction Field Splitter

This block sits right after instruction fetch. It receives a six-byte window of instruction bytes read at the current program counter, with the first instruction byte in the top byte. It splits that window into the fields that the later pipeline stages need: the opcode, the function code, the two register specifiers, the 32-bit constant or address, and the instruction length. From the length it computes the sequential next program counter, and it flags opcodes that the machine does not define.

Every instruction is either two or six bytes long. When a constant or a target address is present, it follows the register byte and is stored most-significant byte first. Jumps and calls follow the same rule: each carries a register byte that is ignored. Register specifiers 8 to 15 mean that no register is named.

The block is combinational by default. Setting `REG_OUT` adds one output register stage.

Top module: `insn_field_decoder`

## Requirements
- R1: `opcode` equals bits 47:44 of `win` and `func` equals bits 43:40.
- R2: `reg_a` equals bits 39:36 and `reg_b` equals bits 35:32. `reg_a_ok` and `reg_b_ok` are high exactly when the matching nibble is in the range 0 to 7.
- R3: Opcodes 3, 4, 5, 7 and 8 give `len` = 6 and `imm` = bits 31:0 of `win`, so byte 2 of the instruction is the most significant byte of `imm`.
- R4: Opcodes 0, 1, 2, 6, 9, 10 and 11 give `len` = 2 and `imm` = 0.
- R5: Opcodes 12 to 15 give `bad_op` = 1, `len` = 2 and `imm` = 0. Every other opcode gives `bad_op` = 0.
- R6: `next_pc` equals `pc + len` modulo 2^ADDR_W, including when the sum wraps past the top of the address space.
- R7: With `REG_OUT` = 0, the outputs follow the inputs in the same cycle.
- R8: With `REG_OUT` = 1, every output shows the value for the inputs sampled at the previous rising edge of `clk`. While `rst_n` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used by the optional output stage |
| rst_n | input | 1 | Active-low asynchronous reset |
| pc | input | ADDR_W | Address of the first byte in the window |
| win | input | 16+IMM_W | Instruction bytes, first byte in the top bits |
| opcode | output | 4 | Instruction class |
| func | output | 4 | Function or condition code |
| reg_a | output | 4 | First register specifier |
| reg_b | output | 4 | Second register specifier |
| reg_a_ok | output | 1 | reg_a names a real register |
| reg_b_ok | output | 1 | reg_b names a real register |
| imm | output | IMM_W | Constant or address, 0 for short forms |
| len | output | 3 | Instruction length in bytes |
| next_pc | output | ADDR_W | Sequential next program counter |
| bad_op | output | 1 | Undefined opcode |

## Verification
On every cycle, the assertions check three things: the distance from `pc` to `next_pc` is always two or six bytes, an undefined opcode always gives a short length with no constant, and every six-byte form carries the constant from the low 32 bits of the window. In the registered variant, they also check that the outputs lag the decode by exactly one cycle. The bench scenarios are what show the rest: that every one of the sixteen opcodes gets its own length, that the register-valid flags flip between 7 and 8, that the byte order of the constant is right, and that the program counter wraps at the top of the address space.

// File: rtl/insn_field_decoder.sv
module insn_field_decoder #(
  parameter int ADDR_W  = 32,
  parameter int IMM_W   = 32,
  parameter bit REG_OUT = 1'b0,
  localparam int WIN_W  = 16 + IMM_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] pc,
  input  logic [WIN_W-1:0]  win,
  output logic [3:0]        opcode,
  output logic [3:0]        func,
  output logic [3:0]        reg_a,
  output logic [3:0]        reg_b,
  output logic              reg_a_ok,
  output logic              reg_b_ok,
  output logic [IMM_W-1:0]  imm,
  output logic [2:0]        len,
  output logic [ADDR_W-1:0] next_pc,
  output logic              bad_op
);

  localparam logic [2:0] LEN_SHORT = 3'd2;
  localparam logic [2:0] LEN_LONG  = 3'd6;

  logic [3:0]        c_op, c_fn, c_ra, c_rb;
  logic              c_long, c_bad;
  logic [2:0]        c_len;
  logic [IMM_W-1:0]  c_imm;
  logic [ADDR_W-1:0] c_npc;

  assign c_op = win[WIN_W-1 -: 4];
  assign c_fn = win[WIN_W-5 -: 4];
  assign c_ra = win[WIN_W-9 -: 4];
  assign c_rb = win[WIN_W-13 -: 4];

  always_comb begin
    c_long = 1'b0;
    c_bad  = 1'b0;
    case (c_op)
      4'h3, 4'h4, 4'h5, 4'h7, 4'h8: c_long = 1'b1;
      4'hC, 4'hD, 4'hE, 4'hF:       c_bad  = 1'b1;
      default: ;
    endcase
  end

  assign c_len = c_long ? LEN_LONG : LEN_SHORT;
  assign c_imm = c_long ? win[IMM_W-1:0] : '0;
  assign c_npc = pc + ADDR_W'(c_len);

  generate
    if (REG_OUT) begin : g_reg
      logic primed;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          opcode   <= '0;
          func     <= '0;
          reg_a    <= '0;
          reg_b    <= '0;
          reg_a_ok <= 1'b0;
          reg_b_ok <= 1'b0;
          imm      <= '0;
          len      <= '0;
          next_pc  <= '0;
          bad_op   <= 1'b0;
          primed   <= 1'b0;
        end else begin
          opcode   <= c_op;
          func     <= c_fn;
          reg_a    <= c_ra;
          reg_b    <= c_rb;
          reg_a_ok <= ~c_ra[3];
          reg_b_ok <= ~c_rb[3];
          imm      <= c_imm;
          len      <= c_len;
          next_pc  <= c_npc;
          bad_op   <= c_bad;
          primed   <= 1'b1;
        end
      end

      // R8
      stage_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        primed |-> (len == $past(c_len) && next_pc == $past(c_npc) && imm == $past(c_imm)));
    end else begin : g_comb
      assign opcode   = c_op;
      assign func     = c_fn;
      assign reg_a    = c_ra;
      assign reg_b    = c_rb;
      assign reg_a_ok = ~c_ra[3];
      assign reg_b_ok = ~c_rb[3];
      assign imm      = c_imm;
      assign len      = c_len;
      assign next_pc  = c_npc;
      assign bad_op   = c_bad;
    end
  endgenerate

  // R6
  step_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((c_npc - pc) == ADDR_W'(2)) || ((c_npc - pc) == ADDR_W'(6)));

  // R5
  bad_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
    c_bad |-> (c_len == LEN_SHORT && c_imm == '0));

  // R3
  long_imm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c_len == LEN_LONG) |-> (c_imm == win[IMM_W-1:0] && !c_bad));

  // R4
  short_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c_len == LEN_SHORT) |-> (c_imm == '0));

endmodule

// File: tb/insn_field_decoder_bench.sv
`timescale 1ns/1ps
module insn_field_decoder_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] pc = '0;
  logic [47:0] win = '0;
  int runs = 0, fails = 0;

  always #4 clk = ~clk;

  logic [3:0] c_op, c_fn, c_ra, c_rb, r_op, r_fn, r_ra, r_rb;
  logic c_aok, c_bok, r_aok, r_bok, c_bad, r_bad;
  logic [31:0] c_imm, r_imm, c_npc, r_npc;
  logic [2:0] c_len, r_len;

  insn_field_decoder u_insn_field_decoder (
    .clk(clk), .rst_n(rst_n), .pc(pc), .win(win),
    .opcode(c_op), .func(c_fn), .reg_a(c_ra), .reg_b(c_rb),
    .reg_a_ok(c_aok), .reg_b_ok(c_bok), .imm(c_imm), .len(c_len),
    .next_pc(c_npc), .bad_op(c_bad));

  insn_field_decoder #(.REG_OUT(1'b1)) u_insn_field_decoder_q (
    .clk(clk), .rst_n(rst_n), .pc(pc), .win(win),
    .opcode(r_op), .func(r_fn), .reg_a(r_ra), .reg_b(r_rb),
    .reg_a_ok(r_aok), .reg_b_ok(r_bok), .imm(r_imm), .len(r_len),
    .next_pc(r_npc), .bad_op(r_bad));

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  typedef struct {
    logic [3:0] op, fn, ra, rb;
    logic aok, bok, bad;
    logic [31:0] imm, npc;
    logic [2:0] len;
  } exp_t;

  function automatic exp_t model(logic [31:0] p, logic [47:0] w);
    exp_t e;
    int op_i;
    e.op = w[47:44]; e.fn = w[43:40]; e.ra = w[39:36]; e.rb = w[35:32];
    e.aok = (int'(e.ra) < 8);
    e.bok = (int'(e.rb) < 8);
    op_i = int'(e.op);
    e.bad = (op_i >= 12);
    e.len = (op_i == 3 || op_i == 4 || op_i == 5 || op_i == 7 || op_i == 8) ? 3'd6 : 3'd2;
    e.imm = (e.len == 3'd6) ? {w[31:24], w[23:16], w[15:8], w[7:0]} : 32'd0;
    e.npc = p + 32'(e.len);
    return e;
  endfunction

  exp_t prev;

  task automatic cmp_comb(exp_t e);
    check("R1 opcode", 64'(c_op), 64'(e.op));
    check("R1 func", 64'(c_fn), 64'(e.fn));
    check("R2 reg_a", 64'(c_ra), 64'(e.ra));
    check("R2 reg_b", 64'(c_rb), 64'(e.rb));
    check("R2 reg_a_ok", 64'(c_aok), 64'(e.aok));
    check("R2 reg_b_ok", 64'(c_bok), 64'(e.bok));
    check(e.len == 3'd6 ? "R3 len" : "R4 len", 64'(c_len), 64'(e.len));
    check(e.len == 3'd6 ? "R3 imm" : "R4 imm", 64'(c_imm), 64'(e.imm));
    check("R5 bad_op", 64'(c_bad), 64'(e.bad));
    check("R6 next_pc", 64'(c_npc), 64'(e.npc));
  endtask

  task automatic cmp_reg(exp_t e);
    check("R8 opcode/func", 64'({r_op, r_fn}), 64'({e.op, e.fn}));
    check("R8 regs", 64'({r_ra, r_rb, r_aok, r_bok}), 64'({e.ra, e.rb, e.aok, e.bok}));
    check("R8 imm", 64'(r_imm), 64'(e.imm));
    check("R8 len/bad", 64'({r_len, r_bad}), 64'({e.len, e.bad}));
    check("R8 next_pc", 64'(r_npc), 64'(e.npc));
  endtask

  // R7: comb outputs checked in the same cycle; R8: registered outputs one cycle later
  task automatic step(logic [31:0] p, logic [47:0] w);
    exp_t e;
    @(negedge clk);
    cmp_reg(prev);
    pc = p; win = w;
    #1;
    e = model(p, w);
    cmp_comb(e);
    prev = e;
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8: outputs cleared while in reset
    check("R8 reset len", 64'(r_len), 64'd0);
    check("R8 reset next_pc", 64'(r_npc), 64'd0);
    check("R8 reset opcode", 64'({r_op, r_fn, r_bad, r_aok, r_bok}), 64'd0);
    rst_n = 1'b1;
    prev = model(pc, win);
    // R1 R3 R4 R5: every opcode with a fixed pattern
    for (int op = 0; op < 16; op++)
      step(32'h0000_1000 + 32'(op * 16), {4'(op), 4'h5, 8'h17, 32'hA1B2_C3D4});
    // R3: jump with ignored register byte, byte order of destination
    step(32'h0000_0200, 48'h7588_0000_1000);
    // R3: load-immediate constant
    step(32'h0000_0040, 48'h30F0_DEAD_BEEF);
    // R2: boundary 7 / 8 specifiers
    step(32'h0, 48'h6178_0000_0000);
    step(32'h0, 48'h6187_0000_0000);
    step(32'h0, 48'h60FF_0000_0000);
    // R6: wrap at top of address space
    step(32'hFFFF_FFFE, 48'h30F3_0000_0001);
    step(32'hFFFF_FFFF, 48'h6101_FFFF_FFFF);
    step(32'hFFFF_FFFC, 48'hC000_1234_5678);
    for (int i = 0; i < 400; i++)
      step($urandom, {16'($urandom), 32'($urandom)});
    @(negedge clk);
    cmp_reg(prev);
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule